// File: doc/BRIEF.md
# Card Read DMA Sequencer

This block runs the data side of a memory-card host while a read is moved out by a DMA engine. Software first loads a block count and the DMA control settings: enable, auto-continue and a 3-bit request threshold code. It then issues a start. The block steps through three phases in order: sending the read command, waiting for the card's response, and receiving data. The command shifter, the response and data receivers with their CRC checkers, and the DMA engine are outside the block. They appear as simple handshake and event inputs.

Received words go into an internal FIFO. A request line tells the DMA engine to pop words from it, and the request follows a fill-level threshold or a forced drain mode. At each block end the block count steps down. In auto mode the next block is armed without a new command until the count runs out. At that point the sequence stops and a sticky end flag is raised. A response error stops the sequence and wipes the DMA control settings. A data error does the same and also empties the FIFO. All flags are cleared by writing 1.

Top module: `crd_rd_dma`

## Requirements
- R1: After reset: busy, cmd_go, rx_arm and dreq are 0, all five flags are 0, the DMA control outputs are 0, fifo_level is 0 and bcnt_left is 0.
- R2: rd_start while idle sets busy and cmd_go in the next cycle. cmd_go stays high until cmd_sent. The block then waits for the response. rsp_ok produces a one-cycle rx_arm pulse in the following cycle. rd_start while busy has no effect.
- R3: rx_valid pushes rx_word into the FIFO only during the data-receive phase. A word offered outside that phase, or while the FIFO holds FIFO_DEPTH words, is dropped.
- R4: bcnt_wr loads bcnt_left only while idle. At each error-free block end the count steps down, saturating at 0. If the result is 0, busy drops and flag bit 4 (transfer end) is set.
- R5: At a block end that leaves a nonzero count, auto=1 keeps busy high and pulses rx_arm in the next cycle without cmd_go. With auto=0 the sequence goes idle, the count is kept and no end flag is set.
- R6: A response CRC error sets flag bit 0 and a response timeout sets flag bit 1. Either one makes the block idle and zeroes enable, auto and threshold code. The FIFO contents are kept.
- R7: A data CRC error sets flag bit 2 and a data timeout sets flag bit 3. Either one makes the block idle, zeroes the DMA control and empties the FIFO.
- R8: With enable=1, dreq is high while fifo_level is at or above the threshold for the code: 0 means FIFO_DEPTH, 1 means FIFO_DEPTH/4, 2 means FIFO_DEPTH/2, 3 means 3*FIFO_DEPTH/4, and 5 to 7 mean FIFO_DEPTH.
- R9: Threshold code 4 (drain) holds dreq high whenever fifo_level is nonzero.
- R10: With enable=0, dreq stays low whatever the fill level.
- R11: Flags are sticky until a 1 is written to the matching flag_clr bit. A flag set in the same cycle as its clear stays set.
- R12: dack pops the FIFO head, and ddata shows words in arrival order. dack on an empty FIFO is ignored. fifo_flush empties the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Write strobe for DMA control |
| ctl_en_in | input | 1 | Enable value to write |
| ctl_auto_in | input | 1 | Auto-continue value to write |
| ctl_thr_in | input | 3 | Threshold code to write |
| ctl_en | output | 1 | Current DMA enable |
| ctl_auto | output | 1 | Current auto-continue setting |
| ctl_thr | output | 3 | Current threshold code |
| bcnt_wr | input | 1 | Block count load strobe |
| bcnt_in | input | CNT_W | Block count to load |
| bcnt_left | output | CNT_W | Blocks remaining |
| rd_start | input | 1 | Start a read sequence |
| fifo_flush | input | 1 | Empty the FIFO |
| flag_clr | input | 5 | Write-1-to-clear for flags |
| flags | output | 5 | Sticky flags: rsp CRC, rsp timeout, data CRC, data timeout, end |
| busy | output | 1 | Sequence in progress |
| cmd_go | output | 1 | Request to send the read command |
| cmd_sent | input | 1 | Command fully sent |
| rsp_ok | input | 1 | Response received without error |
| rsp_crc_bad | input | 1 | Response CRC error |
| rsp_tmo | input | 1 | Response timeout |
| rx_arm | output | 1 | Pulse: start receiving a block |
| rx_valid | input | 1 | Received data word valid |
| rx_word | input | DATA_W | Received data word |
| rx_blk_end | input | 1 | Block received without error |
| rx_crc_bad | input | 1 | Data CRC error |
| rx_tmo | input | 1 | Data timeout |
| fifo_level | output | $clog2(FIFO_DEPTH+1) | FIFO fill level |
| dreq | output | 1 | DMA request |
| dack | input | 1 | DMA pops one word |
| ddata | output | DATA_W | FIFO head word |

## Verification
A wrong sequencer state shows at the ports in the cycle after the event that caused it. Examples are cmd_go or busy at the wrong level, a missing or stray rx_arm pulse, or DMA control that survives an error. A count that is off shows up at the next block end, as an end flag raised a block early or late. A corrupted FIFO pointer or level shows on the next pop as a word out of order or a wrong fill level. Each threshold code is swept over every fill level with enable on and off, so a wrong comparison appears as a dreq mismatch at the exact level where it goes wrong.

// File: rtl/crd_pkg.sv
package crd_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_CMD  = 2'd1,
    SQ_RSP  = 2'd2,
    SQ_DAT  = 2'd3
  } sq_state_e;

  localparam int FL_RSP_CRC = 0;
  localparam int FL_RSP_TMO = 1;
  localparam int FL_DAT_CRC = 2;
  localparam int FL_DAT_TMO = 3;
  localparam int FL_END     = 4;
  localparam int FL_N       = 5;

  localparam logic [2:0] THR_FULL  = 3'd0;
  localparam logic [2:0] THR_Q1    = 3'd1;
  localparam logic [2:0] THR_HALF  = 3'd2;
  localparam logic [2:0] THR_Q3    = 3'd3;
  localparam logic [2:0] THR_DRAIN = 3'd4;

endpackage

// File: rtl/crd_rxfifo.sv
module crd_rxfifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clr,
  input  logic                           push_req,
  input  logic [DATA_W-1:0]              din,
  input  logic                           pop_req,
  output logic [DATA_W-1:0]              dout,
  output logic [$clog2(DEPTH+1)-1:0]     level
);

  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);
  localparam logic [AW-1:0]    PTR_LAST = AW'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp_q, wp_nx, rp_q, rp_nx;
  logic [LVL_W-1:0]  lv_q, lv_nx;
  logic              do_push, do_pop, ptr_en;

  function automatic logic [AW-1:0] ptr_step(input logic [AW-1:0] p);
    return (p == PTR_LAST) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    do_push = push_req && (lv_q != LVL_FULL);
    do_pop  = pop_req && (lv_q != '0);
    wp_nx   = wp_q;
    rp_nx   = rp_q;
    lv_nx   = lv_q;
    if (clr) begin
      wp_nx = '0;
      rp_nx = '0;
      lv_nx = '0;
    end else begin
      if (do_push) wp_nx = ptr_step(wp_q);
      if (do_pop)  rp_nx = ptr_step(rp_q);
      case ({do_push, do_pop})
        2'b10:   lv_nx = lv_q + LVL_W'(1);
        2'b01:   lv_nx = lv_q - LVL_W'(1);
        default: lv_nx = lv_q;
      endcase
    end
    ptr_en = clr || do_push || do_pop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
      lv_q <= '0;
    end else if (ptr_en) begin
      wp_q <= wp_nx;
      rp_q <= rp_nx;
      lv_q <= lv_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wp_q] <= din;
  end

  assign dout  = mem[rp_q];
  assign level = lv_q;

endmodule

// File: rtl/crd_dreq_gen.sv
module crd_dreq_gen #(
  parameter int DEPTH = 8
) (
  input  logic                       en,
  input  logic [2:0]                 thr,
  input  logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       dreq
);
  import crd_pkg::*;

  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam int Q1_I  = (DEPTH / 4 < 1) ? 1 : DEPTH / 4;
  localparam int Q2_I  = (DEPTH / 2 < 1) ? 1 : DEPTH / 2;
  localparam int Q3_I  = ((3 * DEPTH) / 4 < 1) ? 1 : (3 * DEPTH) / 4;
  localparam logic [LVL_W-1:0] LV_Q1   = LVL_W'(Q1_I);
  localparam logic [LVL_W-1:0] LV_Q2   = LVL_W'(Q2_I);
  localparam logic [LVL_W-1:0] LV_Q3   = LVL_W'(Q3_I);
  localparam logic [LVL_W-1:0] LV_FULL = LVL_W'(DEPTH);

  logic [LVL_W-1:0] mark;
  logic             drain, hit;

  always_comb begin
    drain = (thr == THR_DRAIN);
    case (thr)
      THR_Q1:   mark = LV_Q1;
      THR_HALF: mark = LV_Q2;
      THR_Q3:   mark = LV_Q3;
      default:  mark = LV_FULL;
    endcase
    hit  = drain ? (level != '0) : (level >= mark);
    dreq = en && hit;
  end

endmodule

// File: rtl/crd_ctl_regs.sv
module crd_ctl_regs #(
  parameter int NFLAG = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic             en_in,
  input  logic             auto_in,
  input  logic [2:0]       thr_in,
  input  logic             ctl_clear,
  input  logic [NFLAG-1:0] flag_set,
  input  logic [NFLAG-1:0] flag_clr,
  output logic             en,
  output logic             auto_md,
  output logic [2:0]       thr,
  output logic [NFLAG-1:0] flags
);

  logic             en_q, en_nx, auto_q, auto_nx, ctl_ld;
  logic [2:0]       thr_q, thr_nx;
  logic [NFLAG-1:0] fl_q, fl_nx;
  logic             fl_ld;

  always_comb begin
    ctl_ld  = ctl_clear || ctl_wr;
    en_nx   = en_q;
    auto_nx = auto_q;
    thr_nx  = thr_q;
    if (ctl_clear) begin
      en_nx   = 1'b0;
      auto_nx = 1'b0;
      thr_nx  = 3'd0;
    end else if (ctl_wr) begin
      en_nx   = en_in;
      auto_nx = auto_in;
      thr_nx  = thr_in;
    end
    fl_ld = (|flag_set) || (|flag_clr);
    fl_nx = (fl_q & ~flag_clr) | flag_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      auto_q <= 1'b0;
      thr_q  <= 3'd0;
    end else if (ctl_ld) begin
      en_q   <= en_nx;
      auto_q <= auto_nx;
      thr_q  <= thr_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fl_q <= '0;
    else if (fl_ld) fl_q <= fl_nx;
  end

  assign en      = en_q;
  assign auto_md = auto_q;
  assign thr     = thr_q;
  assign flags   = fl_q;

endmodule

// File: rtl/crd_seq_fsm.sv
module crd_seq_fsm #(
  parameter int CNT_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_start,
  input  logic                    cmd_sent,
  input  logic                    rsp_ok,
  input  logic                    rsp_crc_bad,
  input  logic                    rsp_tmo,
  input  logic                    rx_blk_end,
  input  logic                    rx_crc_bad,
  input  logic                    rx_tmo,
  input  logic                    auto_md,
  input  logic                    bcnt_wr,
  input  logic [CNT_W-1:0]        bcnt_in,
  output logic                    busy,
  output logic                    cmd_go,
  output logic                    rx_arm,
  output logic                    rx_open,
  output logic [CNT_W-1:0]        bcnt_left,
  output logic [crd_pkg::FL_N-1:0] flag_set
);
  import crd_pkg::*;

  sq_state_e        st_q, st_nx;
  logic [CNT_W-1:0] cnt_q, cnt_nx, cnt_dec;
  logic             cnt_en, arm_q, arm_nx;

  always_comb begin
    st_nx    = st_q;
    cnt_nx   = cnt_q;
    arm_nx   = 1'b0;
    flag_set = '0;
    cnt_dec  = (cnt_q == '0) ? '0 : cnt_q - CNT_W'(1);
    case (st_q)
      SQ_IDLE: begin
        if (bcnt_wr)  cnt_nx = bcnt_in;
        if (rd_start) st_nx  = SQ_CMD;
      end
      SQ_CMD: begin
        if (cmd_sent) st_nx = SQ_RSP;
      end
      SQ_RSP: begin
        if (rsp_crc_bad || rsp_tmo) begin
          flag_set[FL_RSP_CRC] = rsp_crc_bad;
          flag_set[FL_RSP_TMO] = rsp_tmo;
          st_nx = SQ_IDLE;
        end else if (rsp_ok) begin
          st_nx  = SQ_DAT;
          arm_nx = 1'b1;
        end
      end
      SQ_DAT: begin
        if (rx_crc_bad || rx_tmo) begin
          flag_set[FL_DAT_CRC] = rx_crc_bad;
          flag_set[FL_DAT_TMO] = rx_tmo;
          st_nx = SQ_IDLE;
        end else if (rx_blk_end) begin
          cnt_nx = cnt_dec;
          if (cnt_dec == '0) begin
            flag_set[FL_END] = 1'b1;
            st_nx = SQ_IDLE;
          end else if (auto_md) begin
            arm_nx = 1'b1;
          end else begin
            st_nx = SQ_IDLE;
          end
        end
      end
      default: st_nx = SQ_IDLE;
    endcase
    cnt_en = (cnt_nx != cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      arm_q <= 1'b0;
    end else begin
      st_q  <= st_nx;
      arm_q <= arm_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nx;
  end

  assign busy      = (st_q != SQ_IDLE);
  assign cmd_go    = (st_q == SQ_CMD);
  assign rx_open   = (st_q == SQ_DAT);
  assign rx_arm    = arm_q;
  assign bcnt_left = cnt_q;

endmodule

// File: rtl/crd_rd_dma.sv
module crd_rd_dma
  import crd_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 8,
  parameter int CNT_W      = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            ctl_wr,
  input  logic                            ctl_en_in,
  input  logic                            ctl_auto_in,
  input  logic [2:0]                      ctl_thr_in,
  output logic                            ctl_en,
  output logic                            ctl_auto,
  output logic [2:0]                      ctl_thr,
  input  logic                            bcnt_wr,
  input  logic [CNT_W-1:0]                bcnt_in,
  output logic [CNT_W-1:0]                bcnt_left,
  input  logic                            rd_start,
  input  logic                            fifo_flush,
  input  logic [FL_N-1:0]                 flag_clr,
  output logic [FL_N-1:0]                 flags,
  output logic                            busy,
  output logic                            cmd_go,
  input  logic                            cmd_sent,
  input  logic                            rsp_ok,
  input  logic                            rsp_crc_bad,
  input  logic                            rsp_tmo,
  output logic                            rx_arm,
  input  logic                            rx_valid,
  input  logic [DATA_W-1:0]               rx_word,
  input  logic                            rx_blk_end,
  input  logic                            rx_crc_bad,
  input  logic                            rx_tmo,
  output logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_level,
  output logic                            dreq,
  input  logic                            dack,
  output logic [DATA_W-1:0]               ddata
);

  logic            rst_meta, rst_n_i;
  logic [FL_N-1:0] flag_set;
  logic            rx_open, ctl_clear, fifo_clr, push_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_i  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_i  <= rst_meta;
    end
  end

  assign ctl_clear = |flag_set[FL_DAT_TMO:FL_RSP_CRC];
  assign fifo_clr  = fifo_flush || (|flag_set[FL_DAT_TMO:FL_DAT_CRC]);
  assign push_req  = rx_valid && rx_open;

  crd_seq_fsm #(.CNT_W(CNT_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .rd_start    (rd_start),
    .cmd_sent    (cmd_sent),
    .rsp_ok      (rsp_ok),
    .rsp_crc_bad (rsp_crc_bad),
    .rsp_tmo     (rsp_tmo),
    .rx_blk_end  (rx_blk_end),
    .rx_crc_bad  (rx_crc_bad),
    .rx_tmo      (rx_tmo),
    .auto_md     (ctl_auto),
    .bcnt_wr     (bcnt_wr),
    .bcnt_in     (bcnt_in),
    .busy        (busy),
    .cmd_go      (cmd_go),
    .rx_arm      (rx_arm),
    .rx_open     (rx_open),
    .bcnt_left   (bcnt_left),
    .flag_set    (flag_set)
  );

  crd_ctl_regs #(.NFLAG(FL_N)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .ctl_wr    (ctl_wr),
    .en_in     (ctl_en_in),
    .auto_in   (ctl_auto_in),
    .thr_in    (ctl_thr_in),
    .ctl_clear (ctl_clear),
    .flag_set  (flag_set),
    .flag_clr  (flag_clr),
    .en        (ctl_en),
    .auto_md   (ctl_auto),
    .thr       (ctl_thr),
    .flags     (flags)
  );

  crd_rxfifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .clr      (fifo_clr),
    .push_req (push_req),
    .din      (rx_word),
    .pop_req  (dack),
    .dout     (ddata),
    .level    (fifo_level)
  );

  crd_dreq_gen #(.DEPTH(FIFO_DEPTH)) u_dreq (
    .en    (ctl_en),
    .thr   (ctl_thr),
    .level (fifo_level),
    .dreq  (dreq)
  );

endmodule

// File: rtl/crd_rd_dma_chk.sv
module crd_rd_dma_chk #(
  parameter int FIFO_DEPTH = 8,
  parameter int CNT_W      = 8
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            dreq,
  input logic                            ctl_en,
  input logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_level,
  input logic [4:0]                      flags,
  input logic [4:0]                      flag_clr,
  input logic                            busy,
  input logic [CNT_W-1:0]                bcnt_left,
  input logic                            cmd_go,
  input logic                            rx_arm
);

  p_req_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dreq |-> ctl_en);

  p_req_needs_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dreq |-> (fifo_level != '0));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= ($clog2(FIFO_DEPTH+1))'(FIFO_DEPTH));

  p_cmd_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |-> busy);

  p_arm_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_arm |-> busy);

  p_rsp_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flags[0]) || $rose(flags[1])) |-> (!busy && !ctl_en));

  p_dat_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flags[2]) || $rose(flags[3])) |-> (!busy && !ctl_en && fifo_level == '0));

  p_end_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[4]) |-> (!busy && bcnt_left == '0));

  for (genvar gi = 0; gi < 5; gi++) begin : g_sticky
    p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flags[gi]) |-> $past(flag_clr[gi]));
  end

endmodule

bind crd_rd_dma crd_rd_dma_chk #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dreq       (dreq),
  .ctl_en     (ctl_en),
  .fifo_level (fifo_level),
  .flags      (flags),
  .flag_clr   (flag_clr),
  .busy       (busy),
  .bcnt_left  (bcnt_left),
  .cmd_go     (cmd_go),
  .rx_arm     (rx_arm)
);

// File: tb/tb_crd_rd_dma.sv
module tb_crd_rd_dma;

  localparam int DATA_W = 32;
  localparam int DEPTH  = 8;
  localparam int CNT_W  = 8;
  localparam int LVL_W  = $clog2(DEPTH + 1);

  logic clk, rst_n;
  logic ctl_wr, ctl_en_in, ctl_auto_in;
  logic [2:0] ctl_thr_in;
  logic ctl_en, ctl_auto;
  logic [2:0] ctl_thr;
  logic bcnt_wr;
  logic [CNT_W-1:0] bcnt_in, bcnt_left;
  logic rd_start, fifo_flush;
  logic [4:0] flag_clr, flags;
  logic busy, cmd_go, cmd_sent, rsp_ok, rsp_crc_bad, rsp_tmo, rx_arm;
  logic rx_valid;
  logic [DATA_W-1:0] rx_word, ddata;
  logic rx_blk_end, rx_crc_bad, rx_tmo;
  logic [LVL_W-1:0] fifo_level;
  logic dreq, dack;

  int ncmp = 0;
  int nbad = 0;
  int model[$];
  int wval = 100;

  crd_rd_dma #(.DATA_W(DATA_W), .FIFO_DEPTH(DEPTH), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .ctl_wr(ctl_wr), .ctl_en_in(ctl_en_in), .ctl_auto_in(ctl_auto_in), .ctl_thr_in(ctl_thr_in),
    .ctl_en(ctl_en), .ctl_auto(ctl_auto), .ctl_thr(ctl_thr),
    .bcnt_wr(bcnt_wr), .bcnt_in(bcnt_in), .bcnt_left(bcnt_left),
    .rd_start(rd_start), .fifo_flush(fifo_flush), .flag_clr(flag_clr), .flags(flags),
    .busy(busy), .cmd_go(cmd_go), .cmd_sent(cmd_sent),
    .rsp_ok(rsp_ok), .rsp_crc_bad(rsp_crc_bad), .rsp_tmo(rsp_tmo),
    .rx_arm(rx_arm), .rx_valid(rx_valid), .rx_word(rx_word),
    .rx_blk_end(rx_blk_end), .rx_crc_bad(rx_crc_bad), .rx_tmo(rx_tmo),
    .fifo_level(fifo_level), .dreq(dreq), .dack(dack), .ddata(ddata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    ncmp++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_req(input int en, input int thr, input int lvl);
    int mark;
    if (en == 0) return 0;
    if (thr == 4) return (lvl > 0) ? 1 : 0;
    case (thr)
      1: mark = DEPTH / 4;
      2: mark = DEPTH / 2;
      3: mark = (3 * DEPTH) / 4;
      default: mark = DEPTH;
    endcase
    return (lvl >= mark) ? 1 : 0;
  endfunction

  task automatic set_ctl(input logic e, input logic a, input logic [2:0] t);
    ctl_wr = 1'b1; ctl_en_in = e; ctl_auto_in = a; ctl_thr_in = t;
    tick();
    ctl_wr = 1'b0;
  endtask

  task automatic load_cnt(input int n);
    bcnt_wr = 1'b1; bcnt_in = CNT_W'(n);
    tick();
    bcnt_wr = 1'b0;
  endtask

  task automatic push_word(input int w);
    rx_valid = 1'b1; rx_word = DATA_W'(w);
    tick();
    rx_valid = 1'b0;
  endtask

  task automatic pop_word();
    dack = 1'b1;
    tick();
    dack = 1'b0;
  endtask

  task automatic go_start();  rd_start = 1'b1; tick(); rd_start = 1'b0; endtask
  task automatic go_sent();   cmd_sent = 1'b1; tick(); cmd_sent = 1'b0; endtask
  task automatic go_rsp();    rsp_ok = 1'b1;   tick(); rsp_ok = 1'b0;   endtask
  task automatic go_blkend(); rx_blk_end = 1'b1; tick(); rx_blk_end = 1'b0; endtask
  task automatic clr_flags(input logic [4:0] m); flag_clr = m; tick(); flag_clr = '0; endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    ctl_wr = 0; ctl_en_in = 0; ctl_auto_in = 0; ctl_thr_in = 0;
    bcnt_wr = 0; bcnt_in = 0; rd_start = 0; fifo_flush = 0; flag_clr = 0;
    cmd_sent = 0; rsp_ok = 0; rsp_crc_bad = 0; rsp_tmo = 0;
    rx_valid = 0; rx_word = 0; rx_blk_end = 0; rx_crc_bad = 0; rx_tmo = 0; dack = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();

    // R1 reset state
    chk("R1 busy", busy, 0);        chk("R1 cmd_go", cmd_go, 0);
    chk("R1 rx_arm", rx_arm, 0);    chk("R1 dreq", dreq, 0);
    chk("R1 flags", flags, 0);      chk("R1 ctl_en", ctl_en, 0);
    chk("R1 ctl_auto", ctl_auto, 0); chk("R1 ctl_thr", ctl_thr, 0);
    chk("R1 level", fifo_level, 0); chk("R1 bcnt", bcnt_left, 0);

    // R4 load while idle
    load_cnt(3);
    chk("R4 count load idle", bcnt_left, 3);
    set_ctl(1, 0, 4);
    chk("R1 ctl readback en", ctl_en, 1);
    chk("R1 ctl readback thr", ctl_thr, 4);

    // R2 sequence ordering
    go_start();
    chk("R2 busy after start", busy, 1);
    chk("R2 cmd_go after start", cmd_go, 1);
    rd_start = 1'b1; bcnt_wr = 1'b1; bcnt_in = 8'd9;
    tick();
    rd_start = 1'b0; bcnt_wr = 1'b0;
    chk("R2 start while busy ignored", cmd_go, 1);
    chk("R4 load while busy ignored", bcnt_left, 3);
    repeat (3) tick();
    chk("R2 cmd_go held", cmd_go, 1);
    go_sent();
    chk("R2 cmd_go drops on sent", cmd_go, 0);
    chk("R2 busy waits response", busy, 1);
    chk("R2 no arm before response", rx_arm, 0);
    push_word(7);
    chk("R3 word outside data phase dropped", fifo_level, 0);
    go_rsp();
    chk("R2 rx_arm after response", rx_arm, 1);
    tick();
    chk("R2 rx_arm one cycle", rx_arm, 0);

    // R3 R8 R9 R10 R12 sweep: every code, enable on/off, every level
    for (int t = 0; t < 8; t++) begin
      for (int e = 0; e < 2; e++) begin
        set_ctl(e[0], 1'b0, t[2:0]);
        while (model.size() < DEPTH) begin
          push_word(wval); model.push_back(wval); wval++;
        end
        chk("R3 fill level", fifo_level, DEPTH);
        if (t == 0 && e == 0) begin
          push_word(9999);
          chk("R3 push when full dropped", fifo_level, DEPTH);
        end
        for (int l = DEPTH; l > 0; l--) begin
          if (t == 4)      chk("R9 drain request", dreq, exp_req(e, t, l));
          else if (e == 0) chk("R10 disabled request", dreq, 0);
          else             chk("R8 threshold request", dreq, exp_req(e, t, l));
          chk("R12 data order", int'(ddata), model[0]);
          pop_word();
          void'(model.pop_front());
          chk("R12 level after pop", fifo_level, l - 1);
        end
        chk("R8 no request empty", dreq, 0);
      end
    end

    // R5 non-auto block end
    set_ctl(1, 0, 4);
    push_word(wval); model.push_back(wval); wval++;
    push_word(wval); model.push_back(wval); wval++;
    go_blkend();
    chk("R5 non-auto count", bcnt_left, 2);
    chk("R5 non-auto idle", busy, 0);
    chk("R5 non-auto no end flag", flags, 0);
    chk("R5 non-auto no arm", rx_arm, 0);
    chk("R9 residual drain request", dreq, 1);
    push_word(55);
    chk("R3 idle word dropped", fifo_level, 2);

    // R6 response CRC error
    set_ctl(1, 1, 2);
    go_start(); go_sent();
    rsp_crc_bad = 1'b1; tick(); rsp_crc_bad = 1'b0;
    chk("R6 crc flag", flags, 5'b00001);
    chk("R6 idle", busy, 0);
    chk("R6 en cleared", ctl_en, 0);
    chk("R6 auto cleared", ctl_auto, 0);
    chk("R6 thr cleared", ctl_thr, 0);
    chk("R6 fifo kept", fifo_level, 2);
    chk("R10 request off after abort", dreq, 0);

    // R6 response timeout
    set_ctl(1, 0, 1);
    go_start(); go_sent();
    rsp_tmo = 1'b1; tick(); rsp_tmo = 1'b0;
    chk("R6 timeout flag", flags, 5'b00011);
    chk("R6 timeout en cleared", ctl_en, 0);
    chk("R6 timeout idle", busy, 0);
    chk("R6 timeout fifo kept", fifo_level, 2);

    // R11 selective clear
    clr_flags(5'b00001);
    chk("R11 clear one flag", flags, 5'b00010);
    tick();
    chk("R11 flag sticky", flags, 5'b00010);

    // R12 flush
    fifo_flush = 1'b1; tick(); fifo_flush = 1'b0;
    model.delete();
    chk("R12 flush empties", fifo_level, 0);

    // R7 data CRC error
    set_ctl(1, 0, 4);
    go_start(); go_sent(); go_rsp();
    push_word(1); push_word(2);
    chk("R3 data phase push", fifo_level, 2);
    rx_crc_bad = 1'b1; tick(); rx_crc_bad = 1'b0;
    chk("R7 crc flag", flags, 5'b00110);
    chk("R7 fifo cleared", fifo_level, 0);
    chk("R7 en cleared", ctl_en, 0);
    chk("R7 idle", busy, 0);

    // R7 data timeout
    set_ctl(1, 0, 4);
    go_start(); go_sent(); go_rsp();
    push_word(3);
    rx_tmo = 1'b1; tick(); rx_tmo = 1'b0;
    chk("R7 timeout flag", flags, 5'b01110);
    chk("R7 timeout fifo cleared", fifo_level, 0);
    chk("R7 timeout thr cleared", ctl_thr, 0);
    clr_flags(5'b11111);
    chk("R11 clear all", flags, 0);

    // R4 R5 auto multi-block
    load_cnt(3);
    set_ctl(1, 1, 4);
    go_start(); go_sent(); go_rsp();
    chk("R5 first arm", rx_arm, 1);
    push_word(wval); model.push_back(wval); wval++;
    push_word(wval); model.push_back(wval); wval++;
    go_blkend();
    chk("R4 count step", bcnt_left, 2);
    chk("R5 auto busy", busy, 1);
    chk("R5 auto arm", rx_arm, 1);
    chk("R5 auto no command", cmd_go, 0);
    tick();
    chk("R5 auto arm one cycle", rx_arm, 0);
    go_blkend();
    chk("R4 count step two", bcnt_left, 1);
    chk("R5 auto still busy", busy, 1);
    chk("R4 no early end", flags, 0);
    rx_blk_end = 1'b1; flag_clr = 5'b10000; tick();
    rx_blk_end = 1'b0; flag_clr = '0;
    chk("R4 count zero", bcnt_left, 0);
    chk("R4 end idle", busy, 0);
    chk("R11 set beats clear", flags, 5'b10000);
    chk("R4 end no arm", rx_arm, 0);
    clr_flags(5'b10000);
    chk("R11 end flag cleared", flags, 0);

    // R12 residual drain in order
    for (int k = 0; k < 2; k++) begin
      chk("R9 drain request", dreq, 1);
      chk("R12 residual order", int'(ddata), model[0]);
      pop_word();
      void'(model.pop_front());
    end
    chk("R9 drain stops empty", dreq, 0);
    pop_word();
    chk("R12 pop empty ignored", fifo_level, 0);
    set_ctl(0, 0, 4);
    chk("R10 software disable", ctl_en, 0);

    summary();
    $finish;
  end

endmodule